// File: doc/BRIEF.md
# Three-Level Translation Table Walker

This block turns a 32-bit logical address into a physical address by reading three levels of translation tables held in memory. The first read comes from the root table. Its descriptor points to a pointer table, and that descriptor points to a page table. A client hands over one logical address together with a supervisor/user flag. The walker picks the supervisor or user table base and issues one descriptor read per level on a simple read port. It then returns either the physical address or a fault that names the level where the walk stopped.

Two page sizes are supported, 8 KB and 4 KB, selected by a configuration pin. The page size changes how many address bits index the page table and how many bits pass through unchanged as the page offset.

Both data-carrying interfaces use a valid/ready handshake, and a transfer happens on a clock edge where both are high:
- Request side: the walker raises ready only while it is idle.
- Memory read request: address and valid are held until the memory accepts.
- Memory response: it is a bare valid pulse, which the walker accepts only while it waits for a read.
- Result side: the result is held, unchanged, until the client takes it.

Top module: `table_walker`

## Requirements
- R1: After reset, and whenever no walk is in progress, `req_ready` is 1 while `mem_req_valid` and `rsp_valid` are 0. `req_ready` is 0 from request acceptance until the result is taken, so only one walk is in flight at a time.
- R2: The root table base is `sup_root_base` when `req_super` is 1 and `usr_root_base` when it is 0. Both are sampled at acceptance.
- R3: The first read address is {root base (23 bits), logical address bits 31..25, 2'b00}.
- R4: The second read address is {root descriptor bits 31..9, logical address bits 24..18, 2'b00}.
- R5: The third read address depends on the page size. With `page_8k`=1 it is {pointer descriptor bits 31..7, logical bits 17..13, 2'b00}. With `page_8k`=0 it is {pointer descriptor bits 31..8, logical bits 17..12, 2'b00}.
- R6: Reads are issued strictly in the order root, pointer, page. Each read waits for its response before the next read is requested, and a complete walk makes exactly three reads.
- R7: A root or pointer descriptor with bit 1 clear, or a page descriptor with bit 0 clear, ends the walk at once with `rsp_fault`=1. `rsp_level` is then 1 for root, 2 for pointer or 3 for page, and no further reads are issued.
- R8: A successful walk returns `rsp_fault`=0 and `rsp_level`=0. `rsp_paddr` is {page descriptor bits 31..13, logical bits 12..0} for 8 KB pages, or {page descriptor bits 31..12, logical bits 11..0} for 4 KB pages.
- R9: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the read request and its address stay unchanged on the next cycle.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, the result and its fields stay unchanged on the next cycle.
- R11: The page size is sampled at request acceptance. A change on `page_8k` during a walk has no effect on that walk's third read address or physical address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| page_8k | input | 1 | Page size select: 1 = 8 KB, 0 = 4 KB |
| sup_root_base | input | 23 | Supervisor root table base, address bits 31..9 |
| usr_root_base | input | 23 | User root table base, address bits 31..9 |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Logical address to translate |
| req_super | input | 1 | 1 = supervisor access, 0 = user access |
| mem_req_valid | output | 1 | Descriptor read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Descriptor data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Client takes the result |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Walk ended on an invalid descriptor |
| rsp_level | output | 2 | Failing level: 1 root, 2 pointer, 3 page; 0 on success |

## Verification
The assertions check the following on every cycle:
- Idle, reading and answering are mutually exclusive.
- A pending read request or result holds still under back-pressure.
- No new read appears while a read is outstanding.
- The fault flag and level code agree with each other.

Only the bench scenarios can show the rest. This covers the address arithmetic at each level, the choice of root base, and the descriptor bit that stops the walk at each level. It also covers the physical address for both page sizes, the largest index values, and the fact that a page-size change mid-walk has no effect.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int AW       = 32;             // address and descriptor width
  localparam int IDX_W    = 7;              // root and pointer index width
  localparam int OFF8     = 13;             // offset width, 8 KB page
  localparam int OFF4     = 12;             // offset width, 4 KB page
  localparam int RI_LO    = AW - IDX_W;     // lowest root index bit
  localparam int PI_LO    = RI_LO - IDX_W;  // lowest pointer index bit
  localparam int PG8_W    = PI_LO - OFF8;   // page index width, 8 KB
  localparam int PG4_W    = PI_LO - OFF4;   // page index width, 4 KB
  localparam int TBL_LO   = IDX_W + 2;      // root/pointer table alignment bits
  localparam int PG8_LO   = PG8_W + 2;      // page table alignment, 8 KB
  localparam int PG4_LO   = PG4_W + 2;      // page table alignment, 4 KB
  localparam int BASE_W   = AW - TBL_LO;    // root base width
  localparam int RES_BIT  = 1;              // resident bit, root/pointer level
  localparam int VAL_BIT  = 0;              // valid bit, page level

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_ROOT = 2'd1,
    LVL_PTR  = 2'd2,
    LVL_PAGE = 2'd3
  } lvl_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_RESP
  } st_e;
endpackage

// File: rtl/tw_addr_gen.sv
module tw_addr_gen
  import tw_pkg::*;
(
  input  lvl_e                level,
  input  logic [AW-1:OFF4]    vaddr_hi,
  input  logic [AW-1:PG8_LO]  base_hi,
  input  logic                page_8k,
  output logic [AW-1:0]       addr
);
  always_comb begin
    unique case (level)
      LVL_ROOT: addr = {base_hi[AW-1:TBL_LO], vaddr_hi[AW-1:RI_LO], 2'b00};
      LVL_PTR:  addr = {base_hi[AW-1:TBL_LO], vaddr_hi[RI_LO-1:PI_LO], 2'b00};
      LVL_PAGE: begin
        if (page_8k)
          addr = {base_hi[AW-1:PG8_LO], vaddr_hi[PI_LO-1:OFF8], 2'b00};
        else
          addr = {base_hi[AW-1:PG4_LO], vaddr_hi[PI_LO-1:OFF4], 2'b00};
      end
      default:  addr = '0;
    endcase
  end
endmodule

// File: rtl/tw_desc_check.sv
module tw_desc_check
  import tw_pkg::*;
(
  input  lvl_e        level,
  input  logic [1:0]  flags,
  output logic        usable
);
  always_comb begin
    if (level == LVL_PAGE) usable = flags[VAL_BIT];
    else                   usable = flags[RES_BIT];
  end
endmodule

// File: rtl/table_walker.sv
module table_walker
  import tw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_8k,
  input  logic [BASE_W-1:0] sup_root_base,
  input  logic [BASE_W-1:0] usr_root_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_vaddr,
  input  logic              req_super,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [AW-1:0]     mem_rsp_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [AW-1:0]     rsp_paddr,
  output logic              rsp_fault,
  output logic [1:0]        rsp_level
);
  st_e             state_q;
  lvl_e            level_q;
  lvl_e            fail_lvl_q;
  logic [AW-1:0]   vaddr_q;
  logic            pg8k_q;
  logic [AW-1:0]   addr_q;
  logic [AW-1:0]   paddr_q;
  logic            fault_q;

  lvl_e            gen_level;
  logic [AW-1:OFF4]   gen_vaddr;
  logic [AW-1:PG8_LO] gen_base;
  logic            gen_pg8k;
  logic [AW-1:0]   gen_addr;
  logic            desc_ok;
  logic [AW-1:0]   phys;
  logic [BASE_W-1:0] root_sel;
  logic            unused_desc_bits;

  assign unused_desc_bits = ^mem_rsp_data[PG8_LO-1:2];

  // The root base is chosen while idle, the following levels come from the fetched descriptor
  assign root_sel  = req_super ? sup_root_base : usr_root_base;
  assign gen_level = (state_q == ST_IDLE) ? LVL_ROOT : lvl_e'(level_q + 2'd1);
  assign gen_vaddr = (state_q == ST_IDLE) ? req_vaddr[AW-1:OFF4] : vaddr_q[AW-1:OFF4];
  assign gen_base  = (state_q == ST_IDLE) ? {root_sel, {(TBL_LO-PG8_LO){1'b0}}}
                                          : mem_rsp_data[AW-1:PG8_LO];
  assign gen_pg8k  = pg8k_q;

  tw_addr_gen i_addr_gen (
    .level    (gen_level),
    .vaddr_hi (gen_vaddr),
    .base_hi  (gen_base),
    .page_8k  (gen_pg8k),
    .addr     (gen_addr)
  );

  tw_desc_check i_desc_check (
    .level  (level_q),
    .flags  (mem_rsp_data[1:0]),
    .usable (desc_ok)
  );

  assign phys = pg8k_q ? {mem_rsp_data[AW-1:OFF8], vaddr_q[OFF8-1:0]}
                       : {mem_rsp_data[AW-1:OFF4], vaddr_q[OFF4-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      level_q    <= LVL_NONE;
      fail_lvl_q <= LVL_NONE;
      vaddr_q    <= '0;
      pg8k_q     <= 1'b0;
      addr_q     <= '0;
      paddr_q    <= '0;
      fault_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            vaddr_q <= req_vaddr;
            pg8k_q  <= page_8k;
            addr_q  <= gen_addr;
            level_q <= LVL_ROOT;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (mem_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (!desc_ok) begin
              fault_q    <= 1'b1;
              fail_lvl_q <= level_q;
              paddr_q    <= '0;
              state_q    <= ST_RESP;
            end else if (level_q == LVL_PAGE) begin
              fault_q    <= 1'b0;
              fail_lvl_q <= LVL_NONE;
              paddr_q    <= phys;
              state_q    <= ST_RESP;
            end else begin
              addr_q  <= gen_addr;
              level_q <= lvl_e'(level_q + 2'd1);
              state_q <= ST_ISSUE;
            end
          end
        end
        ST_RESP: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_ISSUE);
  assign mem_req_addr  = addr_q;
  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_paddr     = paddr_q;
  assign rsp_fault     = fault_q;
  assign rsp_level     = fail_lvl_q;
endmodule

// File: rtl/tw_checker.sv
module tw_checker
  import tw_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          mem_rsp_valid,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [AW-1:0] rsp_paddr,
  input logic          rsp_fault,
  input logic [1:0]    rsp_level
);
  logic outstanding;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              outstanding <= 1'b0;
    else if (mem_req_valid && mem_req_ready) outstanding <= 1'b1;
    else if (mem_rsp_valid)                  outstanding <= 1'b0;
  end

  AST_PHASE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, mem_req_valid, rsp_valid})); // R1

  AST_NO_READ_WHILE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !mem_req_valid); // R6

  AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R9

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)
                                   && $stable(rsp_fault) && $stable(rsp_level))); // R10

  AST_FAULT_HAS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_level != 2'd0)); // R7

  AST_SUCCESS_NO_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_level == 2'd0)); // R8
endmodule

bind table_walker tw_checker i_tw_checker (.*);

// File: tb/test_table_walker.sv
`timescale 1ns/1ps
module test_table_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        page_8k = 1'b1;
  logic [22:0] sup_root_base = 23'h1A2B3C;
  logic [22:0] usr_root_base = 23'h054321;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_super = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic [1:0]  rsp_level;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] rd_log [0:7];
  int rd_cnt = 0;
  int stall_cfg = 0;

  table_walker i_table_walker (.*);

  always #2.5 clk = ~clk;

  task automatic check_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model: optional stall before accept, response one cycle after accept
  initial begin
    bit pending = 0;
    logic [31:0] pend_addr = '0;
    int wait_cnt = 0;
    forever begin
      @(negedge clk);
      if (pending) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem.exists(pend_addr) ? mem[pend_addr] : 32'h0;
        pending = 0;
      end else begin
        mem_rsp_valid = 1'b0;
      end
      if (mem_req_valid) begin
        if (wait_cnt >= stall_cfg) begin
          mem_req_ready = 1'b1;
          pending = 1;
          pend_addr = mem_req_addr;
          if (rd_cnt < 8) rd_log[rd_cnt] = mem_req_addr;
          rd_cnt++;
        end else begin
          mem_req_ready = 1'b0;
          if (wait_cnt > 0 && mem_req_addr !== pend_addr) begin
            n_chk++; n_fail++;
            $display("FAIL R9 address moved under stall: actual %h expected %h", mem_req_addr, pend_addr);
          end
          pend_addr = mem_req_addr;
          wait_cnt++;
        end
      end else begin
        mem_req_ready = 1'b0;
        wait_cnt = 0;
      end
    end
  end

  function automatic logic [31:0] f_root(logic [22:0] b, logic [31:0] va);
    return {b, va[31:25], 2'b00};
  endfunction
  function automatic logic [31:0] f_ptr(logic [31:0] d, logic [31:0] va);
    return {d[31:9], va[24:18], 2'b00};
  endfunction
  function automatic logic [31:0] f_page(logic [31:0] d, logic [31:0] va, bit p8);
    return p8 ? {d[31:7], va[17:13], 2'b00} : {d[31:8], va[17:12], 2'b00};
  endfunction
  function automatic logic [31:0] f_phys(logic [31:0] d, logic [31:0] va, bit p8);
    return p8 ? {d[31:13], va[12:0]} : {d[31:12], va[11:0]};
  endfunction

  task automatic run_case(string name, logic [31:0] va, bit sup, bit p8,
                          logic [31:0] rd, logic [31:0] pd, logic [31:0] gd,
                          int hold, bit flip);
    logic [31:0] a0, a1, a2, exp_pa, got_pa;
    logic [1:0]  exp_lvl, got_lvl;
    logic        got_f;
    int exp_reads, t;
    a0 = f_root(sup ? sup_root_base : usr_root_base, va);
    a1 = f_ptr(rd, va);
    a2 = f_page(pd, va, p8);
    mem.delete();
    mem[a0] = rd; mem[a1] = pd; mem[a2] = gd;
    if (!rd[1])      exp_lvl = 2'd1;
    else if (!pd[1]) exp_lvl = 2'd2;
    else if (!gd[0]) exp_lvl = 2'd3;
    else             exp_lvl = 2'd0;
    exp_reads = (exp_lvl == 0) ? 3 : int'(exp_lvl);
    exp_pa = (exp_lvl == 0) ? f_phys(gd, va, p8) : 32'h0;
    rd_cnt = 0;
    page_8k = p8; req_super = sup; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (flip) page_8k = !p8;
    t = 0;
    while (!rsp_valid && t < 500) begin @(negedge clk); t++; end
    check_eq("R6", {name, " result arrived"}, {31'd0, rsp_valid}, 32'd1);
    got_pa = rsp_paddr; got_f = rsp_fault; got_lvl = rsp_level;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check_eq("R10", {name, " result held"}, rsp_paddr, got_pa);
      check_eq("R10", {name, " valid held"}, {31'd0, rsp_valid}, 32'd1);
      check_eq("R1", {name, " busy blocks request"}, {31'd0, req_ready}, 32'd0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check_eq("R1", {name, " idle again"}, {31'd0, req_ready}, 32'd1);
    check_eq("R6 R7", {name, " read count"}, rd_cnt, exp_reads);
    check_eq("R2 R3", {name, " root read addr"}, rd_log[0], a0);
    if (exp_reads > 1) check_eq("R4", {name, " pointer read addr"}, rd_log[1], a1);
    if (exp_reads > 2) check_eq("R5 R11", {name, " page read addr"}, rd_log[2], a2);
    check_eq("R7 R8", {name, " fault flag"}, {31'd0, got_f}, {31'd0, exp_lvl != 0});
    check_eq("R7", {name, " fault level"}, {30'd0, got_lvl}, {30'd0, exp_lvl});
    check_eq("R8 R11", {name, " physical address"}, got_pa, exp_pa);
    page_8k = p8;
  endtask

  task automatic t_reset;
    check_eq("R1", "reset req_ready", {31'd0, req_ready}, 32'd1);
    check_eq("R1", "reset mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
    check_eq("R1", "reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_super_8k;   // R2 R3 R4 R5 R8
    run_case("super8k", 32'h8A5C_3ABC, 1'b1, 1'b1, 32'h0004_0002, 32'h0010_0482, 32'h7654_2001, 0, 1'b0);
  endtask
  task automatic t_user_4k;    // R2 R5 R8
    run_case("user4k", 32'h1357_9BDF, 1'b0, 1'b0, 32'h00AB_C202, 32'h0123_4502, 32'hFEDC_B001, 0, 1'b0);
  endtask
  task automatic t_root_fault; // R7 root uses bit 1
    run_case("rootflt", 32'h4444_0000, 1'b1, 1'b1, 32'h0004_0001, 32'h0010_0002, 32'h0000_2001, 0, 1'b0);
  endtask
  task automatic t_ptr_fault;  // R7
    run_case("ptrflt", 32'h2468_ACE0, 1'b0, 1'b0, 32'h0020_0002, 32'h0030_0001, 32'h0000_3001, 0, 1'b0);
  endtask
  task automatic t_page_fault; // R7 page uses bit 0
    run_case("pageflt", 32'hC0DE_1234, 1'b1, 1'b1, 32'h0050_0002, 32'h0060_0002, 32'h0ABC_E002, 0, 1'b0);
  endtask
  task automatic t_stall;      // R9
    stall_cfg = 3;
    run_case("stall", 32'h0F0F_F0F0, 1'b0, 1'b1, 32'h0070_0002, 32'h0080_0082, 32'h1111_E001, 0, 1'b0);
    stall_cfg = 0;
  endtask
  task automatic t_hold;       // R10
    run_case("hold", 32'h5555_AAAA, 1'b1, 1'b0, 32'h0090_0002, 32'h00A0_0102, 32'h2222_3001, 4, 1'b0);
  endtask
  task automatic t_cfg_flip;   // R11
    run_case("flip8k", 32'h3C3C_5A5A, 1'b1, 1'b1, 32'h00B0_0002, 32'h00C0_0082, 32'h3333_A001, 0, 1'b1);
    run_case("flip4k", 32'h3C3C_5A5A, 1'b0, 1'b0, 32'h00D0_0002, 32'h00E0_0102, 32'h4444_B001, 0, 1'b1);
  endtask
  task automatic t_max_index;  // R3 R4 R5 boundary
    run_case("maxidx", 32'hFFFF_FFFF, 1'b0, 1'b0, 32'hFF00_0002, 32'hEE00_0002, 32'hDDDD_D001, 0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_super_8k();
    t_user_4k();
    t_root_fault();
    t_ptr_fault();
    t_page_fault();
    t_stall();
    t_hold();
    t_cfg_flip();
    t_max_index();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule